// File: doc/BRIEF.md
# Chip-Select Configuration Register Bank

This block is the software-visible configuration store of an external memory controller. A word-addressed register port gives access to five kinds of 32-bit state: a free-form control word, a read-only copy of the power-on strap word, an address-mask register, and one configuration word plus one timing word per chip select. Downstream logic that drives the memory pins reads the configuration and timing words. This block only stores them.

Alongside the register port, the block compares every incoming system address against all chip selects, with no clock in the path. Only the address bits from bit 22 upward take part in the comparison. The result is a one-hot vector naming the chip select that owns the address. When more than one chip select matches, the lowest index wins.

Chip select 0 comes out of reset already enabled. Its memory kind and data width are taken from the strap word, so the boot memory can be fetched before any software has run.

Top module: `mcfg_cs_bank`

## Requirements
- R1: While `rst` is high at a rising edge, the control word, the mask register and the configuration and timing words of chip selects 1..7 become zero. Chip select 0's configuration word becomes: bit 0 (enable) = 1, bits [3:1] (memory kind) = {0, strap[3:2]}, bits [5:4] (data width) = strap[1:0], all other bits 0.
- R2: At reset, chip select 0's timing word is loaded according to its memory kind code: 0 (SDRAM) gives 0x07FF03FF, 1 (synchronous-burst SRAM) gives 0x00000003, 2 (asynchronous) gives 0x03FFFFFF, 3 (generic synchronous) gives 0x01FFFFFF.
- R3: Offset 0x04 reads the value `strap_i` had at the last rising edge with `rst` high. Writes to 0x04 and later changes of `strap_i` leave that value unchanged.
- R4: `warn_o` is high for exactly the one cycle that follows a rising edge at which a write to offset 0x04 was presented. It is low at all other times.
- R5: A write to offset 0x08 stores `reg_wdata[7:0] & 0x7F`. A read of 0x08 returns that value, zero-extended.
- R6: Chip select i has its configuration word at offset 0x10 + 8*i and its timing word at 0x14 + 8*i. Offset bit 2 selects timing (1) or configuration (0). Both words store and return all 32 bits.
- R7: Offset 0x00 is a 32-bit control word that stores and returns any value.
- R8: Offsets 0x0C and 0x50 through 0xFC read as zero. Writes to them change no register.
- R9: Chip select i is a candidate for `sys_addr_i` when its configuration bit 0 is 1 and `(sys_addr_i & (mask << 22)) == (cfg[23:16] << 22)`, evaluated on 32 bits. The evaluation is combinational.
- R10: `cs_sel_o` has bit i set for the lowest-index candidate only. It is all zero when there is no candidate.
- R11: After a write to the mask register, `cs_sel_o` uses the new mask from the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; strap word sampled while high |
| strap_i | input | 32 | Power-on configuration strap word |
| reg_off | input | 8 | Register byte offset |
| reg_we | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_off`, combinational |
| warn_o | output | 1 | One-cycle pulse after a write to the read-only strap register |
| sys_addr_i | input | 32 | System address to be decoded |
| cs_sel_o | output | 8 | One-hot chip-select match vector |

## Verification
Any corruption of a stored word shows up on `reg_rdata` in the same cycle its offset is presented. A wrong configuration word or mask shows up on `cs_sel_o` in the same cycle the affected address is presented, so each address sweep exposes a bad enable, select field or mask bit at once. Overlapping chip selects, a select field with bits outside the mask, and disabled entries with otherwise matching fields make an error in the priority or enable logic visible as a wrong or extra one-hot bit. A broken strap latch or warning register shows one cycle after the write or reset that should have set it.

// File: rtl/mcfg_pkg.sv
package mcfg_pkg;

  localparam int DATA_W      = 32;
  localparam int CFG_EN_BIT  = 0;
  localparam int CFG_KIND_LSB = 1;
  localparam int CFG_KIND_W  = 3;
  localparam int CFG_BW_LSB  = 4;
  localparam int CFG_BW_W    = 2;
  localparam int CFG_SEL_LSB = 16;

  typedef enum logic [2:0] {
    MK_SDRAM = 3'd0,
    MK_SSRAM = 3'd1,
    MK_ASYNC = 3'd2,
    MK_SYNC  = 3'd3
  } mem_kind_e;

  localparam logic [DATA_W-1:0] TIM_SDRAM = 32'h07FF_03FF;
  localparam logic [DATA_W-1:0] TIM_SSRAM = 32'h0000_0003;
  localparam logic [DATA_W-1:0] TIM_ASYNC = 32'h03FF_FFFF;
  localparam logic [DATA_W-1:0] TIM_SYNC  = 32'h01FF_FFFF;

  typedef struct packed {
    logic ctl;
    logic poc;
    logic mask;
    logic pair;
    logic tim;
    logic none;
  } reg_dec_t;

  // Default timing word for a memory kind code
  function automatic logic [DATA_W-1:0] tim_default(input logic [CFG_KIND_W-1:0] kind);
    case (kind)
      MK_SDRAM: return TIM_SDRAM;
      MK_SSRAM: return TIM_SSRAM;
      MK_ASYNC: return TIM_ASYNC;
      MK_SYNC:  return TIM_SYNC;
      default:  return '0;
    endcase
  endfunction

  // Boot configuration word built from the strap nibble
  function automatic logic [DATA_W-1:0] cfg_from_strap(input logic [3:0] s);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CFG_EN_BIT] = 1'b1;
    w[CFG_KIND_LSB +: CFG_KIND_W] = {1'b0, s[3:2]};
    w[CFG_BW_LSB +: CFG_BW_W] = s[1:0];
    return w;
  endfunction

  // Masked region compare of an address against pre-shifted mask and select
  function automatic logic region_hit(input logic [DATA_W-1:0] addr,
                                      input logic [DATA_W-1:0] mask_sh,
                                      input logic [DATA_W-1:0] sel_sh);
    return (addr & mask_sh) == sel_sh;
  endfunction

endpackage

// File: rtl/mcfg_decode.sv
module mcfg_decode
  import mcfg_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int OFF_W  = 8,
  localparam int IDX_W = $clog2(NUM_CS)
) (
  input  logic [OFF_W-1:0] off,
  output reg_dec_t         dec,
  output logic [IDX_W-1:0] idx
);

  localparam logic [OFF_W:0] CS_LO = (OFF_W+1)'(16);
  localparam logic [OFF_W:0] CS_HI = (OFF_W+1)'(16 + 8 * NUM_CS);

  logic [OFF_W:0] off_x;
  assign off_x = {1'b0, off};

  always_comb begin
    dec.ctl  = off_x[OFF_W:2] == (OFF_W-1)'(0);
    dec.poc  = off_x[OFF_W:2] == (OFF_W-1)'(1);
    dec.mask = off_x[OFF_W:2] == (OFF_W-1)'(2);
    dec.pair = (off_x >= CS_LO) && (off_x < CS_HI);
    dec.tim  = dec.pair && off_x[2];
    dec.none = !(dec.ctl || dec.poc || dec.mask || dec.pair);
    idx      = IDX_W'((off_x - CS_LO) >> 3);
  end

endmodule

// File: rtl/mcfg_cs_match.sv
module mcfg_cs_match
  import mcfg_pkg::*;
#(
  parameter int NUM_CS    = 8,
  parameter int MASK_W    = 8,
  parameter int SEL_SHIFT = 22
) (
  input  logic [DATA_W-1:0] addr,
  input  logic [MASK_W-1:0] mask,
  input  logic [NUM_CS-1:0] en,
  input  logic [MASK_W-1:0] sel [NUM_CS],
  output logic [NUM_CS-1:0] cand
);

  logic [DATA_W-1:0] mask_sh;
  assign mask_sh = DATA_W'(mask) << SEL_SHIFT;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    logic [DATA_W-1:0] sel_sh;
    assign sel_sh  = DATA_W'(sel[i]) << SEL_SHIFT;
    assign cand[i] = en[i] && region_hit(addr, mask_sh, sel_sh);
  end

endmodule

// File: rtl/mcfg_prio.sv
module mcfg_prio #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);

  // Isolate the lowest set bit
  assign gnt = req & (~req + N'(1));

endmodule

// File: rtl/mcfg_cs_bank.sv
module mcfg_cs_bank
  import mcfg_pkg::*;
#(
  parameter int              NUM_CS     = 8,
  parameter int              OFF_W      = 8,
  parameter int              MASK_W     = 8,
  parameter logic [MASK_W-1:0] MASK_VALID = 8'h7F,
  parameter int              SEL_SHIFT  = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] strap_i,
  input  logic [OFF_W-1:0]  reg_off,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              warn_o,
  input  logic [DATA_W-1:0] sys_addr_i,
  output logic [NUM_CS-1:0] cs_sel_o
);

  localparam int IDX_W = $clog2(NUM_CS);

  reg_dec_t          dec;
  logic [IDX_W-1:0]  idx;

  logic [DATA_W-1:0] ctl_q;
  logic [DATA_W-1:0] poc_q;
  logic [MASK_W-1:0] mask_q;
  logic [DATA_W-1:0] cfg_q [NUM_CS];
  logic [DATA_W-1:0] tim_q [NUM_CS];
  logic              warn_q;

  // Named write events
  logic              wr_ctl, wr_poc, wr_mask;
  logic [NUM_CS-1:0] wr_cfg, wr_tim;
  logic              oor_hit;

  logic [NUM_CS-1:0] cs_en;
  logic [MASK_W-1:0] cs_sel [NUM_CS];
  logic [NUM_CS-1:0] cand_vec;

  mcfg_decode #(.NUM_CS(NUM_CS), .OFF_W(OFF_W)) u_dec (
    .off (reg_off),
    .dec (dec),
    .idx (idx)
  );

  assign wr_ctl  = reg_we && dec.ctl;
  assign wr_poc  = reg_we && dec.poc;
  assign wr_mask = reg_we && dec.mask;
  assign oor_hit = dec.none;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      poc_q  <= strap_i;
      mask_q <= '0;
      warn_q <= 1'b0;
    end else begin
      warn_q <= wr_poc;
      if (wr_ctl)  ctl_q  <= reg_wdata;
      if (wr_mask) mask_q <= reg_wdata[MASK_W-1:0] & MASK_VALID;
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_slot
    localparam logic [DATA_W-1:0] CFG_ZERO = '0;

    assign wr_cfg[i] = reg_we && dec.pair && !dec.tim && (idx == IDX_W'(i));
    assign wr_tim[i] = reg_we && dec.tim && (idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        if (i == 0) begin
          cfg_q[i] <= cfg_from_strap(strap_i[3:0]);
          tim_q[i] <= tim_default({1'b0, strap_i[3:2]});
        end else begin
          cfg_q[i] <= CFG_ZERO;
          tim_q[i] <= CFG_ZERO;
        end
      end else begin
        if (wr_cfg[i]) cfg_q[i] <= reg_wdata;
        if (wr_tim[i]) tim_q[i] <= reg_wdata;
      end
    end

    assign cs_en[i]  = cfg_q[i][CFG_EN_BIT];
    assign cs_sel[i] = cfg_q[i][CFG_SEL_LSB +: MASK_W];
  end

  always_comb begin
    reg_rdata = '0;
    if (dec.ctl)       reg_rdata = ctl_q;
    else if (dec.poc)  reg_rdata = poc_q;
    else if (dec.mask) reg_rdata = DATA_W'(mask_q);
    else if (dec.pair) reg_rdata = dec.tim ? tim_q[idx] : cfg_q[idx];
  end

  assign warn_o = warn_q;

  mcfg_cs_match #(.NUM_CS(NUM_CS), .MASK_W(MASK_W), .SEL_SHIFT(SEL_SHIFT)) u_match (
    .addr (sys_addr_i),
    .mask (mask_q),
    .en   (cs_en),
    .sel  (cs_sel),
    .cand (cand_vec)
  );

  mcfg_prio #(.N(NUM_CS)) u_prio (
    .req (cand_vec),
    .gnt (cs_sel_o)
  );

endmodule

// File: rtl/mcfg_cs_bank_chk.sv
module mcfg_cs_bank_chk #(
  parameter int                NUM_CS     = 8,
  parameter int                MASK_W     = 8,
  parameter logic [MASK_W-1:0] MASK_VALID = 8'h7F
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_poc,
  input logic              warn_o,
  input logic [31:0]       poc_q,
  input logic [MASK_W-1:0] mask_q,
  input logic [NUM_CS-1:0] cand_vec,
  input logic [NUM_CS-1:0] cs_sel_o,
  input logic              oor_hit,
  input logic [31:0]       reg_rdata
);

  // R4
  warn_src_chk: assert property (@(posedge clk) disable iff (rst)
    warn_o |-> $past(wr_poc));

  // R4
  warn_set_chk: assert property (@(posedge clk) disable iff (rst)
    wr_poc |=> warn_o);

  // R3
  poc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(poc_q));

  // R5
  mask_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_q & ~MASK_VALID) == '0);

  // R10
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cs_sel_o));

  // R9
  sel_from_cand_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_sel_o & ~cand_vec) == '0);

  // R10
  sel_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (cand_vec != '0) |-> (cs_sel_o != '0));

  // R8
  oor_zero_chk: assert property (@(posedge clk) disable iff (rst)
    oor_hit |-> (reg_rdata == '0));

endmodule

bind mcfg_cs_bank mcfg_cs_bank_chk #(
  .NUM_CS(NUM_CS), .MASK_W(MASK_W), .MASK_VALID(MASK_VALID)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_poc    (wr_poc),
  .warn_o    (warn_o),
  .poc_q     (poc_q),
  .mask_q    (mask_q),
  .cand_vec  (cand_vec),
  .cs_sel_o  (cs_sel_o),
  .oor_hit   (oor_hit),
  .reg_rdata (reg_rdata)
);

// File: tb/tb_mcfg_cs_bank.sv
`timescale 1ns/1ps
module tb_mcfg_cs_bank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] strap_i = '0;
  logic [7:0]  reg_off = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        warn_o;
  logic [31:0] sys_addr_i = '0;
  logic [7:0]  cs_sel_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // Bench model of the register contents
  logic [31:0] m_ctl, m_poc;
  logic [7:0]  m_mask;
  logic [31:0] m_cfg [8];
  logic [31:0] m_tim [8];

  always #2.5 clk = ~clk;

  mcfg_cs_bank dut (
    .clk(clk), .rst(rst), .strap_i(strap_i), .reg_off(reg_off),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .warn_o(warn_o), .sys_addr_i(sys_addr_i), .cs_sel_o(cs_sel_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_tim(input int kind);
    case (kind)
      0: return 32'h07FF_03FF;
      1: return 32'h0000_0003;
      2: return 32'h03FF_FFFF;
      3: return 32'h01FF_FFFF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [7:0] exp_sel(input logic [31:0] a);
    for (int i = 0; i < 8; i++) begin
      logic [31:0] msh, ssh;
      msh = {24'h0, m_mask} << 22;
      ssh = {24'h0, m_cfg[i][23:16]} << 22;
      if (m_cfg[i][0] && ((a & msh) == ssh)) return 8'(1 << i);
    end
    return 8'h0;
  endfunction

  task automatic do_reset(input logic [31:0] s);
    @(negedge clk);
    strap_i = s; rst = 1'b1; reg_we = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_ctl = '0; m_mask = '0; m_poc = s;
    for (int i = 0; i < 8; i++) begin m_cfg[i] = '0; m_tim[i] = '0; end
    m_cfg[0] = 32'((s & 3) << 4) | 32'(((s >> 2) & 3) << 1) | 32'h1;
    m_tim[0] = exp_tim(int'((s >> 2) & 3));
  endtask

  task automatic wr(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    reg_off = off; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    if (off[7:2] == 6'd0) m_ctl = d;
    else if (off[7:2] == 6'd2) m_mask = d[7:0] & 8'h7F;
    else if (off >= 8'h10 && off < 8'h50) begin
      if (off[2]) m_tim[(off - 8'h10) >> 3] = d;
      else        m_cfg[(off - 8'h10) >> 3] = d;
    end
  endtask

  task automatic rd(input logic [7:0] off, output logic [31:0] d);
    reg_we = 1'b0; reg_off = off;
    #1;
    d = reg_rdata;
  endtask

  task automatic check_all(input string req);
    logic [31:0] v;
    rd(8'h00, v); chk(v == m_ctl, req, v, m_ctl);
    rd(8'h04, v); chk(v == m_poc, req, v, m_poc);
    rd(8'h08, v); chk(v == {24'h0, m_mask}, req, v, {24'h0, m_mask});
    for (int i = 0; i < 8; i++) begin
      rd(8'(8'h10 + 8 * i), v); chk(v == m_cfg[i], req, v, m_cfg[i]);
      rd(8'(8'h14 + 8 * i), v); chk(v == m_tim[i], req, v, m_tim[i]);
    end
  endtask

  task automatic sweep(input string req);
    for (int h = 0; h < 1024; h++) begin
      sys_addr_i = (32'(h) << 22) | 32'h0015_A5A3;
      #1;
      chk(cs_sel_o == exp_sel(sys_addr_i), req, {24'h0, cs_sel_o}, {24'h0, exp_sel(sys_addr_i)});
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    // R1 R2 R3: reset state for every strap nibble
    for (int s = 0; s < 16; s++) begin
      do_reset(32'h5A3C_9E00 | 32'(s));
      check_all("R1 R2 R3 reset state");
      chk(warn_o == 1'b0, "R4 idle after reset", {31'h0, warn_o}, 32'h0);
      sys_addr_i = 32'hFFFF_FFFF; #1;
      chk(cs_sel_o == 8'h01, "R9 boot select", {24'h0, cs_sel_o}, 32'h1);
    end

    // R3: strap changes after reset do not reach the register
    strap_i = 32'h0; rd(8'h04, v);
    chk(v == m_poc, "R3 strap change", v, m_poc);

    // R3 R4: write to read-only strap register
    wr(8'h04, 32'hDEAD_BEEF);
    chk(warn_o == 1'b1, "R4 warn pulse", {31'h0, warn_o}, 32'h1);
    rd(8'h04, v); chk(v == m_poc, "R3 write ignored", v, m_poc);
    @(negedge clk);
    chk(warn_o == 1'b0, "R4 pulse length", {31'h0, warn_o}, 32'h0);

    // R7 R4: control word
    wr(8'h00, 32'h1357_9BDF);
    chk(warn_o == 1'b0, "R4 no warn on ctl", {31'h0, warn_o}, 32'h0);
    rd(8'h00, v); chk(v == 32'h1357_9BDF, "R7 ctl rw", v, 32'h1357_9BDF);

    // R5: mask filtering
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, v); chk(v == 32'h7F, "R5 mask valid bits", v, 32'h7F);
    wr(8'h08, 32'h0000_012A); rd(8'h08, v); chk(v == 32'h2A, "R5 mask store", v, 32'h2A);

    // R6: pair layout, write all then read all
    for (int i = 0; i < 8; i++) begin
      wr(8'(8'h10 + 8 * i), 32'hA000_0000 ^ (32'(i) * 32'h0101_1111));
      wr(8'(8'h14 + 8 * i), ~(32'hA000_0000 ^ (32'(i) * 32'h0101_1111)) ^ 32'(i));
    end
    check_all("R6 pair readback");

    // R8: out-of-range writes and reads
    wr(8'h0C, 32'hFFFF_FFFF);
    for (int o = 8'h50; o < 256; o += 4) wr(8'(o), 32'hFFFF_FFFF);
    rd(8'h0C, v); chk(v == 32'h0, "R8 read 0x0C", v, 32'h0);
    for (int o = 8'h50; o < 256; o += 4) begin
      rd(8'(o), v); chk(v == 32'h0, "R8 read high", v, 32'h0);
    end
    check_all("R8 no side effect");

    // R9 R10: overlapping, masked-out and disabled entries
    wr(8'h08, 32'h7F);
    wr(8'h10, 32'h0000_0001);
    wr(8'h18, 32'h0005_0021);
    wr(8'h20, 32'h0080_0001);
    wr(8'h28, 32'h0005_0001);
    wr(8'h30, 32'h0006_0000);
    wr(8'h38, 32'h007F_0005);
    wr(8'h40, 32'h0010_0001);
    wr(8'h48, 32'h0010_0000);
    sweep("R9 R10 match sweep");

    // R11: new mask takes effect at once
    wr(8'h08, 32'h70);
    sweep("R11 mask change");
    wr(8'h08, 32'h00);
    sweep("R11 zero mask R10 lowest wins");

    // R10: nothing enabled gives zero
    for (int i = 0; i < 8; i++) wr(8'(8'h10 + 8 * i), 32'h0000_0000);
    sweep("R10 none enabled");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule